// File: doc/BRIEF.md
# Port Statistics Snapshot Engine

This block holds a free-running event counter for every slot of every switch port and gives host software a way to read a port's counters as one consistent set. Per-port increment strobes arrive from frame classification logic outside the block. Each strobe adds one to its counter. Software reaches the block through a small 16-bit register window. Writing a command to the operation register either freezes the full counter set of one port into a capture buffer, or selects one captured 32-bit value. A busy flag in the operation register stays set while the command runs. Software polls the flag until it clears, then fetches the selected value as two 16-bit halves.

A 64-bit statistic uses two neighbouring slots. The low word sits at slot n and the high word at slot n+1. The carry out of slot n feeds slot n+1, and a pair-mask parameter picks which slots form such pairs. The live counters never stop. Only a snapshot command changes what the capture buffer holds, so software can read one frozen set of values over many slow bus accesses.

Top module: `stat_snapshot_engine`

## Requirements
- R1: A synchronous active-high reset clears every live counter, the capture buffer, the result value and the stored operation register. Afterwards the operation register, both result registers and address 3 all read 0x0000.
- R2: Writing address 0 with bits [15:10] = 6'b110111 (0xDC00 base) and a port number in bits [9:0] copies every slot of that port into the capture buffer, one slot per cycle, starting at slot 0. Busy (bit 15 of address 0) is set on the cycle after the write and stays set for exactly NUM_SLOTS cycles.
- R3: Writing address 0 with bits [15:10] = 6'b110011 (0xCC00 base) and a slot index in bits [9:0] selects that captured value. Busy stays set for exactly 2 cycles, and the result is valid when busy clears.
- R4: Address 1 returns bits [31:16] of the selected value and address 2 returns bits [15:0]. Address 3 reads zero. Read data is registered and reflects the register state one clock after the address is presented.
- R5: The counter for port p, slot s adds one on every cycle in which strobe bit p*NUM_SLOTS+s is high. It wraps to zero after 2^CNT_W - 1 and is zero-extended to 32 bits on readout.
- R6: When PAIR_MASK bit n is set, a strobe that wraps slot n also adds one to slot n+1 of the same port, in the same cycle as that slot's own strobe.
- R7: The capture buffer keeps its contents until the next snapshot command. The result registers change only when a read command completes.
- R8: Live counters keep counting while a snapshot or read command is in progress.
- R9: A snapshot of a port number of NUM_PORTS or above fills the capture buffer with zeros. It keeps the same NUM_SLOTS-cycle busy time.
- R10: A read of an index of NUM_SLOTS or above returns zero. It keeps the same 2-cycle busy time.
- R11: The following writes change nothing: a write to address 0 while busy, a write with bit 15 clear, a write with an unrecognised code in bits [14:10], and any write to addresses 1 to 3. In these cases the operation register readback and the results stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_inc_i | input | NUM_PORTS*NUM_SLOTS | Increment strobes, bit p*NUM_SLOTS+s for port p slot s |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 operation, 1 result high, 2 result low |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data for the addressed register |

## Verification
The embedded assertions check four things on every cycle:
- A busy period lasts NUM_SLOTS cycles for a snapshot and two cycles for a read.
- The stored command holds while a command is running.
- The result value moves only when a read completes.
- A counter that is not the high half of a pair holds its value whenever its strobe is low.

Some behaviours can only be shown by the directed scenarios:
- Wrap at the counter width and the carry into the paired slot, which need a long run of strobes.
- The high-then-low word order.
- The zero values returned for out-of-range port and index arguments.
- That the frozen buffer keeps its values while live counts move on.

// File: rtl/stat_pkg.sv
package stat_pkg;
  // command code held in operation register bits [14:10] (bit 15 is busy/go)
  localparam logic [4:0] OP_SNAP = 5'b10111;
  localparam logic [4:0] OP_READ = 5'b10011;
  localparam int         ARG_W   = 10;
  localparam int         RD_CYC  = 2;

  localparam logic [1:0] REG_OP     = 2'd0;
  localparam logic [1:0] REG_RES_HI = 2'd1;
  localparam logic [1:0] REG_RES_LO = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SNAP,
    ST_RD_FETCH,
    ST_RD_LOAD
  } ctrl_state_e;
endpackage

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int NP    = 4,
  parameter int NS    = 16,
  parameter int CNT_W = 32,
  parameter logic [NS-1:0] PAIR_MASK = NS'(1),
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP*NS-1:0] inc_i,
  input  logic [PW-1:0]    sel_port_i,
  input  logic [SW-1:0]    sel_slot_i,
  output logic [CNT_W-1:0] sel_val_o
);
  localparam int TOTAL = NP * NS;
  // slots that receive a carry from the slot below them
  localparam logic [NS-1:0] HIGH_MASK = PAIR_MASK << 1;

  logic [CNT_W-1:0] cnt_q [TOTAL];
  logic [TOTAL-1:0] carry_w;

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_port
      logic [NS-1:0] port_carry;
      always_comb begin
        port_carry    = '0;
        for (int s = 1; s < NS; s++) begin
          port_carry[s] = HIGH_MASK[s] & inc_i[gp*NS+s-1] & (&cnt_q[gp*NS+s-1]);
        end
      end
      assign carry_w[gp*NS +: NS] = port_carry;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TOTAL; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        cnt_q[i] <= cnt_q[i] + CNT_W'(inc_i[i]) + CNT_W'(carry_w[i]);
      end
    end
  end

  always_comb begin
    int flat;
    flat = int'(sel_port_i) * NS + int'(sel_slot_i);
    sel_val_o = '0;
    if (flat < TOTAL) sel_val_o = cnt_q[flat];
  end

  genvar gi;
  generate
    for (gi = 0; gi < TOTAL; gi++) begin : g_chk
      if (!HIGH_MASK[gi % NS]) begin : g_plain
        // R5
        cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
          !inc_i[gi] |=> $stable(cnt_q[gi]));
      end
    end
  endgenerate
endmodule

// File: rtl/stat_capture_buf.sv
module stat_capture_buf #(
  parameter int NS = 16,
  parameter int DW = 32,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [SW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rdata_o <= mem_q[raddr_i];
    end
  end
endmodule

// File: rtl/stat_cmd_ctrl.sv
module stat_cmd_ctrl
  import stat_pkg::*;
#(
  parameter int NP    = 4,
  parameter int NS    = 16,
  parameter int CNT_W = 32,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int RW = $clog2(NS + RD_CYC + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_wr_i,
  input  logic [15:0]      op_wdata_i,
  output logic             busy_o,
  output logic [14:0]      op_q_o,
  output logic [PW-1:0]    sel_port_o,
  output logic [SW-1:0]    sel_slot_o,
  input  logic [CNT_W-1:0] live_val_i,
  output logic             buf_we_o,
  output logic [SW-1:0]    buf_waddr_o,
  output logic [31:0]      buf_wdata_o,
  output logic [SW-1:0]    buf_raddr_o,
  input  logic [31:0]      buf_rdata_i,
  output logic [31:0]      res_o
);
  ctrl_state_e      state_q;
  logic [14:0]      op_q;
  logic [ARG_W-1:0] arg_q;
  logic [SW-1:0]    slot_q;
  logic             port_ok_q;
  logic             idx_ok_q;
  logic [31:0]      res_q;

  wire [4:0] code_w = op_wdata_i[14:10];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      arg_q     <= '0;
      slot_q    <= '0;
      port_ok_q <= 1'b0;
      idx_ok_q  <= 1'b0;
      res_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (op_wr_i && op_wdata_i[15]) begin
            if (code_w == OP_SNAP) begin
              op_q      <= op_wdata_i[14:0];
              arg_q     <= op_wdata_i[ARG_W-1:0];
              port_ok_q <= (op_wdata_i[ARG_W-1:0] < ARG_W'(NP));
              slot_q    <= '0;
              state_q   <= ST_SNAP;
            end else if (code_w == OP_READ) begin
              op_q     <= op_wdata_i[14:0];
              arg_q    <= op_wdata_i[ARG_W-1:0];
              idx_ok_q <= (op_wdata_i[ARG_W-1:0] < ARG_W'(NS));
              state_q  <= ST_RD_FETCH;
            end
          end
        end
        ST_SNAP: begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == SW'(NS - 1)) state_q <= ST_IDLE;
        end
        ST_RD_FETCH: state_q <= ST_RD_LOAD;
        ST_RD_LOAD: begin
          res_q   <= idx_ok_q ? buf_rdata_i : 32'h0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign op_q_o      = op_q;
  assign sel_port_o  = arg_q[PW-1:0];
  assign sel_slot_o  = slot_q;
  assign buf_we_o    = (state_q == ST_SNAP);
  assign buf_waddr_o = slot_q;
  assign buf_wdata_o = port_ok_q ? 32'(live_val_i) : 32'h0;
  assign buf_raddr_o = arg_q[SW-1:0];
  assign res_o       = res_q;

  // checker state: length of the current busy period
  logic [RW-1:0] busy_run_q;
  logic          kind_snap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run_q  <= '0;
      kind_snap_q <= 1'b0;
    end else begin
      busy_run_q <= busy_o ? busy_run_q + 1'b1 : '0;
      if (!busy_o) kind_snap_q <= op_wr_i && op_wdata_i[15] && (code_w == OP_SNAP);
    end
  end

  // R2 R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_run_q == (kind_snap_q ? RW'(NS) : RW'(RD_CYC))));

  // R11
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && op_wr_i) |=> $stable(op_q_o));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RD_LOAD) |=> $stable(res_o));
endmodule

// File: rtl/stat_snapshot_engine.sv
module stat_snapshot_engine
  import stat_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_SLOTS = 16,
  parameter int CNT_W     = 32,
  parameter logic [NUM_SLOTS-1:0] PAIR_MASK = NUM_SLOTS'(1),
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_SLOTS-1:0] evt_inc_i,
  input  logic                           reg_wr_i,
  input  logic [1:0]                     reg_addr_i,
  input  logic [15:0]                    reg_wdata_i,
  output logic [15:0]                    reg_rdata_o
);
  logic             busy;
  logic [14:0]      op_q;
  logic [PW-1:0]    sel_port;
  logic [SW-1:0]    sel_slot;
  logic [CNT_W-1:0] live_val;
  logic             buf_we;
  logic [SW-1:0]    buf_waddr;
  logic [31:0]      buf_wdata;
  logic [SW-1:0]    buf_raddr;
  logic [31:0]      buf_rdata;
  logic [31:0]      res;

  wire op_wr = reg_wr_i && (reg_addr_i == REG_OP);

  stat_counter_bank #(
    .NP(NUM_PORTS), .NS(NUM_SLOTS), .CNT_W(CNT_W), .PAIR_MASK(PAIR_MASK)
  ) u_bank (
    .clk(clk), .rst(rst), .inc_i(evt_inc_i),
    .sel_port_i(sel_port), .sel_slot_i(sel_slot), .sel_val_o(live_val)
  );

  stat_capture_buf #(.NS(NUM_SLOTS), .DW(32)) u_buf (
    .clk(clk), .rst(rst), .we_i(buf_we), .waddr_i(buf_waddr),
    .wdata_i(buf_wdata), .raddr_i(buf_raddr), .rdata_o(buf_rdata)
  );

  stat_cmd_ctrl #(.NP(NUM_PORTS), .NS(NUM_SLOTS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .op_wr_i(op_wr), .op_wdata_i(reg_wdata_i),
    .busy_o(busy), .op_q_o(op_q), .sel_port_o(sel_port), .sel_slot_o(sel_slot),
    .live_val_i(live_val), .buf_we_o(buf_we), .buf_waddr_o(buf_waddr),
    .buf_wdata_o(buf_wdata), .buf_raddr_o(buf_raddr), .buf_rdata_i(buf_rdata),
    .res_o(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else begin
      case (reg_addr_i)
        REG_OP:     reg_rdata_o <= {busy, op_q};
        REG_RES_HI: reg_rdata_o <= res[31:16];
        REG_RES_LO: reg_rdata_o <= res[15:0];
        default:    reg_rdata_o <= '0;
      endcase
    end
  end

  // R4
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr_i) == 2'd3) |-> (reg_rdata_o == 16'h0));
endmodule

// File: tb/sim_stat_snapshot_engine.sv
module sim_stat_snapshot_engine;
  localparam int NP = 4;
  localparam int NS = 8;
  localparam int CW = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP*NS-1:0]  evt = '0;
  logic              wr = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [15:0]       wdata = 16'h0;
  logic [15:0]       rdata;

  int checks = 0;
  int errors = 0;
  int hold_cnt = 0;

  always #5 clk = ~clk;

  stat_snapshot_engine #(
    .NUM_PORTS(NP), .NUM_SLOTS(NS), .CNT_W(CW), .PAIR_MASK(8'b0000_0101)
  ) u0 (
    .clk(clk), .rst(rst), .evt_inc_i(evt), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // bench count of edges on which port 3 slot 6 strobe was high
  always @(posedge clk) if (!rst && evt[3*NS+6]) hold_cnt <= hold_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic poll(output int n);
    logic [15:0] v;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      reg_rd(2'd0, v);
      if (!v[15]) break;
      n++;
    end
  endtask

  task automatic pulse(input int idx, input int n);
    evt[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  task automatic snap(input int port, input string tag);
    int n;
    reg_wr(2'd0, 16'hDC00 | 16'(port));
    poll(n);
    chk({tag, " snapshot busy cycles"}, n, NS);
  endtask

  task automatic rd_slot(input int idx, input string tag, output logic [31:0] v);
    int n;
    logic [15:0] hi, lo;
    reg_wr(2'd0, 16'hCC00 | 16'(idx));
    poll(n);
    chk({tag, " read busy cycles"}, n, 2);
    reg_rd(2'd1, hi);
    reg_rd(2'd2, lo);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [15:0] v;
    logic [31:0] r;
    reg_rd(2'd0, v); chk("R1 op reg after reset", v, 0);
    reg_rd(2'd1, v); chk("R1 result hi after reset", v, 0);
    reg_rd(2'd2, v); chk("R1 result lo after reset", v, 0);
    reg_rd(2'd3, v); chk("R4 addr3 reads zero", v, 0);
    rd_slot(0, "R1", r); chk("R1 buffer zero after reset", r, 0);
  endtask

  task automatic t_basic();
    logic [31:0] r;
    pulse(1*NS+3, 7);
    pulse(0*NS+3, 2);
    snap(1, "R2");
    rd_slot(3, "R3", r); chk("R5 port1 slot3 count", r, 7);
    rd_slot(2, "R3", r); chk("R2 port1 slot2 untouched", r, 0);
    snap(0, "R2");
    rd_slot(3, "R3", r); chk("R2 port0 slot3 count", r, 2);
  endtask

  task automatic t_wide();
    logic [31:0] r;
    evt[0*NS+0] = 1'b1;
    evt[2*NS+4] = 1'b1;
    repeat (65541) @(negedge clk);
    evt[2*NS+4] = 1'b0;
    repeat (131075 - 65541) @(negedge clk);
    evt[0*NS+0] = 1'b0;
    snap(0, "R5");
    rd_slot(0, "R5", r); chk("R5 wrap of low slot", r, 3);
    rd_slot(1, "R6", r); chk("R6 carry into pair high", r, 1);
    snap(2, "R4");
    rd_slot(4, "R4", r); chk("R4 high then low word order", r, 32'h0001_0005);
  endtask

  task automatic t_hold();
    logic [31:0] r;
    logic [15:0] v;
    snap(1, "R7");
    pulse(1*NS+3, 5);
    rd_slot(3, "R7", r); chk("R7 buffer frozen after snapshot", r, 7);
    reg_wr(2'd1, 16'hFFFF);
    reg_wr(2'd2, 16'hFFFF);
    reg_rd(2'd1, v); chk("R11 write to result hi ignored", v, 0);
    reg_rd(2'd2, v); chk("R11 write to result lo ignored", v, 7);
  endtask

  task automatic t_live();
    logic [31:0] r;
    evt[3*NS+6] = 1'b1;
    snap(3, "R8");
    rd_slot(6, "R8", r);
    evt[3*NS+6] = 1'b0;
    @(negedge clk);
    snap(3, "R8");
    rd_slot(6, "R8", r); chk("R8 counting continued during commands", r, hold_cnt);
    chk("R8 strobe spanned the commands", (hold_cnt > NS + 2) ? 1 : 0, 1);
  endtask

  task automatic t_oor();
    logic [31:0] r;
    snap(1, "R10");
    rd_slot(3, "R10", r); chk("R10 valid read before", r, 12);
    rd_slot(NS, "R10", r); chk("R10 out-of-range index reads zero", r, 0);
    snap(NP, "R9");
    rd_slot(3, "R9", r); chk("R9 out-of-range port slot3 zero", r, 0);
    rd_slot(0, "R9", r); chk("R9 out-of-range port slot0 zero", r, 0);
  endtask

  task automatic t_ignore();
    int n;
    logic [15:0] v;
    logic [31:0] r;
    reg_wr(2'd0, 16'hDC02);
    reg_wr(2'd0, 16'hCC03);
    poll(n); chk("R11 busy length with write during busy", n, NS - 1);
    reg_rd(2'd0, v); chk("R11 op reg keeps snapshot command", v, 16'h5C02);
    reg_wr(2'd0, 16'h4C01);
    reg_rd(2'd0, v); chk("R11 write with bit15 clear ignored", v, 16'h5C02);
    reg_wr(2'd0, 16'h8000);
    reg_rd(2'd0, v); chk("R11 unknown code ignored", v, 16'h5C02);
    rd_slot(4, "R11", r); chk("R11 buffer holds port2", r, 32'h0001_0005);
  endtask

  task automatic t_reset2();
    logic [15:0] v;
    logic [31:0] r;
    pulse(0*NS+5, 4);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    reg_rd(2'd1, v); chk("R1 result hi cleared", v, 0);
    reg_rd(2'd2, v); chk("R1 result lo cleared", v, 0);
    rd_slot(4, "R1", r); chk("R1 buffer cleared", r, 0);
    snap(0, "R1");
    rd_slot(5, "R1", r); chk("R1 live counter cleared", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_wide();
    t_hold();
    t_live();
    t_oor();
    t_ignore();
    t_reset2();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule